// File: doc/BRIEF.md
# Next-PC and Branch Target Unit

This block holds the program counter of a simple 32-bit load-store processor and decides, every clock, where the next instruction will be fetched from. The decoder gives it a control-flow kind, the two immediate fields of the instruction (a 16-bit branch offset and a 26-bit jump field), the index and value of the source register, and the index of the link destination. From these the block forms the fall-through address, the branch and jump targets, and the zero or non-zero test on the source register. It then selects the next PC and raises a taken flag.

For the two linking kinds it also produces the return address. This is the PC of the instruction after the current one, together with the index of the register that receives it and a write enable. All of this is combinational. The only state is the PC register, which loads the selected next PC on every rising clock edge and returns to the reset vector while reset is held.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, `pc` holds 0x00000000. After reset is released, `pc` takes the value `next_pc` had at each rising clock edge.
- R2: Kind code 0 (sequential) gives `next_pc` = `pc` + 4 with `taken` = 0. The addition wraps modulo 2^32.
- R3: Kind code 1 (branch if zero) is taken when the source operand is zero. When taken, `next_pc` = `pc` + 4 + (offset << 2), where the offset is `imm16`. When not taken, `next_pc` = `pc` + 4.
- R4: Kind code 2 (branch if non-zero) is taken when the source operand is non-zero. It uses the same target and fall-through rules as R3.
- R5: The branch offset is sign-extended from bit 15 of `imm16`, so an offset with bit 15 set moves the target backwards.
- R6: Kind code 3 (jump) is always taken. Its target keeps bits 31..28 of `pc` + 4, places `imm26` in bits 27..2, and sets bits 1..0 to zero.
- R7: Kind code 5 (jump via register) is always taken. Its target is the whole 32-bit source operand.
- R8: Kind code 4 (jump and link) uses the target of R6. It drives `link_we` = 1, `link_idx` = 31 and `link_val` = `pc` + 4.
- R9: Kind code 6 (jump via register and link) uses the target of R7. It drives `link_idx` = `dst_idx` and `link_val` = `pc` + 4. `link_we` is 1 unless `dst_idx` is 0.
- R10: When `src_idx` is 0, the source operand reads as zero whatever `src_val` carries. A branch-if-zero is then always taken, a branch-if-non-zero is never taken, and a jump via register goes to 0.
- R11: `link_we` is 0 for every kind other than codes 4 and 6. The unused code 7 behaves as sequential.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the PC updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cf_kind | input | 3 | Control-flow kind code of the current instruction |
| src_idx | input | 5 | Index of the source register tested or used as target |
| src_val | input | 32 | Value read from the source register |
| dst_idx | input | 5 | Link destination index for the register-linking kind |
| imm16 | input | 16 | Branch offset field, in instruction words |
| imm26 | input | 26 | Jump field, in instruction words |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Address selected for the following instruction |
| taken | output | 1 | Control transfer away from the fall-through address |
| link_we | output | 1 | Write enable for the return address |
| link_idx | output | 5 | Register index receiving the return address |
| link_val | output | 32 | Return address (current PC plus 4) |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 4-byte instruction step, 16- and 26-bit offset fields, register 31 as the fixed link target, and the hardwired-zero variant of register 0. With these values, a jump via register can park the PC anywhere in the address space. This puts two boundaries within reach: the 256 MB region boundary that the jump field must inherit from PC + 4 rather than from PC, and the 32-bit wrap of the fall-through adder. Directed steps cover these, along with backward offsets and the register-0 operand. A long run of random kinds, indices and values follows, compared on every cycle against a behavioural model.

// File: rtl/npc_pkg.sv
package npc_pkg;

   typedef enum logic [2:0] {
      CF_SEQ  = 3'd0,
      CF_BEQZ = 3'd1,
      CF_BNEZ = 3'd2,
      CF_JMP  = 3'd3,
      CF_JAL  = 3'd4,
      CF_JR   = 3'd5,
      CF_JALR = 3'd6
   } cf_kind_e;

   localparam int unsigned KIND_W = 3;

endpackage

// File: rtl/npc_seq_adder.sv
module npc_seq_adder #(
   parameter int unsigned XLEN = 32,
   parameter int unsigned STEP = 4
) (
   input  logic [XLEN-1:0] pc_i,
   output logic [XLEN-1:0] pc_next_seq_o
);

   localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

   if (STEP == 0) begin : g_bad_step
      $error("npc_seq_adder: STEP must be non-zero");
   end

   assign pc_next_seq_o = pc_i + STEP_V;

endmodule

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
   import npc_pkg::*;
#(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned RIDX_W  = 5,
   parameter bit          ZERO_HW = 1'b1
) (
   input  logic [KIND_W-1:0] kind_i,
   input  logic [RIDX_W-1:0] src_idx_i,
   input  logic [XLEN-1:0]   src_val_i,
   output logic [XLEN-1:0]   opnd_o,
   output logic              cond_o
);

   logic opnd_zero;

   if (ZERO_HW) begin : g_zero_hw
      assign opnd_o = (src_idx_i == '0) ? '0 : src_val_i;
   end else begin : g_zero_soft
      logic unused_idx;
      assign unused_idx = ^src_idx_i;
      assign opnd_o     = src_val_i;
   end

   assign opnd_zero = (opnd_o == '0);

   always_comb begin
      unique case (kind_i)
         CF_BEQZ: cond_o = opnd_zero;
         CF_BNEZ: cond_o = !opnd_zero;
         default: cond_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/npc_target_sel.sv
module npc_target_sel
   import npc_pkg::*;
#(
   parameter int unsigned XLEN   = 32,
   parameter int unsigned BOFS_W = 16,
   parameter int unsigned JOFS_W = 26,
   parameter int unsigned SH     = 2
) (
   input  logic [KIND_W-1:0] kind_i,
   input  logic [XLEN-1:0]   pc4_i,
   input  logic [BOFS_W-1:0] imm16_i,
   input  logic [JOFS_W-1:0] imm26_i,
   input  logic [XLEN-1:0]   opnd_i,
   input  logic              cond_i,
   output logic [XLEN-1:0]   next_o,
   output logic              taken_o
);

   localparam int unsigned BEXT_W = XLEN - BOFS_W - SH;
   localparam int unsigned JTOP   = JOFS_W + SH;

   if (BOFS_W + SH >= XLEN) begin : g_bad_bofs
      $error("npc_target_sel: branch offset does not fit the address");
   end
   if (JTOP >= XLEN) begin : g_bad_jofs
      $error("npc_target_sel: jump field leaves no region bits");
   end

   logic [XLEN-1:0] br_ofs;
   logic [XLEN-1:0] br_tgt;
   logic [XLEN-1:0] jmp_tgt;

   assign br_ofs  = {{BEXT_W{imm16_i[BOFS_W-1]}}, imm16_i, {SH{1'b0}}};
   assign br_tgt  = pc4_i + br_ofs;
   assign jmp_tgt = {pc4_i[XLEN-1:JTOP], imm26_i, {SH{1'b0}}};

   always_comb begin
      next_o  = pc4_i;
      taken_o = 1'b0;
      unique case (kind_i)
         CF_BEQZ, CF_BNEZ: begin
            taken_o = cond_i;
            if (cond_i) next_o = br_tgt;
         end
         CF_JMP, CF_JAL: begin
            taken_o = 1'b1;
            next_o  = jmp_tgt;
         end
         CF_JR, CF_JALR: begin
            taken_o = 1'b1;
            next_o  = opnd_i;
         end
         default: begin
            taken_o = 1'b0;
            next_o  = pc4_i;
         end
      endcase
   end

endmodule

// File: rtl/npc_link_gen.sv
module npc_link_gen
   import npc_pkg::*;
#(
   parameter int unsigned XLEN     = 32,
   parameter int unsigned RIDX_W   = 5,
   parameter int unsigned LINK_REG = 31
) (
   input  logic [KIND_W-1:0] kind_i,
   input  logic [XLEN-1:0]   pc4_i,
   input  logic [RIDX_W-1:0] dst_idx_i,
   output logic              we_o,
   output logic [RIDX_W-1:0] idx_o,
   output logic [XLEN-1:0]   val_o
);

   localparam logic [RIDX_W-1:0] LINK_IDX = RIDX_W'(LINK_REG);

   if (LINK_REG >= (1 << RIDX_W) || LINK_REG == 0) begin : g_bad_link
      $error("npc_link_gen: fixed link register outside the file");
   end

   assign val_o = pc4_i;

   always_comb begin
      we_o  = 1'b0;
      idx_o = dst_idx_i;
      unique case (kind_i)
         CF_JAL: begin
            we_o  = 1'b1;
            idx_o = LINK_IDX;
         end
         CF_JALR: begin
            we_o  = (dst_idx_i != '0);
            idx_o = dst_idx_i;
         end
         default: begin
            we_o  = 1'b0;
            idx_o = dst_idx_i;
         end
      endcase
   end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
   import npc_pkg::*;
#(
   parameter int unsigned   XLEN      = 32,
   parameter int unsigned   STEP      = 4,
   parameter int unsigned   BOFS_W    = 16,
   parameter int unsigned   JOFS_W    = 26,
   parameter int unsigned   RIDX_W    = 5,
   parameter int unsigned   LINK_REG  = 31,
   parameter bit            ZERO_HW   = 1'b1,
   parameter logic [31:0]   RESET_VEC = 32'h0000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cf_kind,
   input  logic [4:0]        src_idx,
   input  logic [31:0]       src_val,
   input  logic [4:0]        dst_idx,
   input  logic [15:0]       imm16,
   input  logic [25:0]       imm26,
   output logic [31:0]       pc,
   output logic              taken,
   output logic [31:0]       next_pc,
   output logic              link_we,
   output logic [4:0]        link_idx,
   output logic [31:0]       link_val
);

   localparam int unsigned SH   = $clog2(STEP);
   localparam int unsigned JTOP = JOFS_W + SH;
   localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

   if (XLEN != 32 || RIDX_W != 5 || BOFS_W != 16 || JOFS_W != 26) begin : g_bad_ports
      $error("npc_unit: port widths are fixed at the top level");
   end
   if ((1 << SH) != STEP) begin : g_bad_step
      $error("npc_unit: STEP must be a power of two");
   end

   logic [XLEN-1:0] pc_q;
   logic [XLEN-1:0] pc4;
   logic [XLEN-1:0] opnd;
   logic            cond;

   npc_seq_adder #(.XLEN(XLEN), .STEP(STEP)) i_seq (
      .pc_i          (pc_q),
      .pc_next_seq_o (pc4)
   );

   npc_cond_eval #(.XLEN(XLEN), .RIDX_W(RIDX_W), .ZERO_HW(ZERO_HW)) i_cond (
      .kind_i    (cf_kind),
      .src_idx_i (src_idx),
      .src_val_i (src_val),
      .opnd_o    (opnd),
      .cond_o    (cond)
   );

   npc_target_sel #(.XLEN(XLEN), .BOFS_W(BOFS_W), .JOFS_W(JOFS_W), .SH(SH)) i_tgt (
      .kind_i  (cf_kind),
      .pc4_i   (pc4),
      .imm16_i (imm16),
      .imm26_i (imm26),
      .opnd_i  (opnd),
      .cond_i  (cond),
      .next_o  (next_pc),
      .taken_o (taken)
   );

   npc_link_gen #(.XLEN(XLEN), .RIDX_W(RIDX_W), .LINK_REG(LINK_REG)) i_link (
      .kind_i    (cf_kind),
      .pc4_i     (pc4),
      .dst_idx_i (dst_idx),
      .we_o      (link_we),
      .idx_o     (link_idx),
      .val_o     (link_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_q <= RESET_VEC;
      else        pc_q <= next_pc;
   end

   assign pc = pc_q;

   AST_PC_TRACKS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> pc == $past(next_pc)); // R1
   AST_SEQ_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
      (cf_kind == CF_SEQ) |-> (!taken && next_pc == pc + STEP_V)); // R2
   AST_BRANCH_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
      ((cf_kind == CF_BEQZ || cf_kind == CF_BNEZ) && !taken) |-> next_pc == pc + STEP_V); // R3
   AST_JUMP_REGION: assert property (@(posedge clk) disable iff (!rst_n)
      (cf_kind == CF_JMP || cf_kind == CF_JAL)
      |-> (taken && next_pc[XLEN-1:JTOP] == pc4[XLEN-1:JTOP])); // R6
   AST_ZERO_REG_BEQZ: assert property (@(posedge clk) disable iff (!rst_n)
      (cf_kind == CF_BEQZ && src_idx == '0 && ZERO_HW) |-> taken); // R10
   AST_JAL_FIXED_DEST: assert property (@(posedge clk) disable iff (!rst_n)
      (cf_kind == CF_JAL) |-> (link_we && link_idx == 5'(LINK_REG))); // R8
   AST_LINK_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      link_we |-> link_val == pc + STEP_V); // R8
   AST_LINK_KIND_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      link_we |-> (cf_kind == CF_JAL || cf_kind == CF_JALR)); // R11

endmodule

// File: tb/test_npc_unit.sv
module test_npc_unit;

   localparam time HALF = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cf_kind = '0;
   logic [4:0]  src_idx = '0;
   logic [31:0] src_val = '0;
   logic [4:0]  dst_idx = '0;
   logic [15:0] imm16 = '0;
   logic [25:0] imm26 = '0;
   logic [31:0] pc, next_pc, link_val;
   logic        taken, link_we;
   logic [4:0]  link_idx;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [31:0] exp_pc = 32'h0;

   always #(HALF) clk = ~clk;

   npc_unit i_npc_unit (
      .clk(clk), .rst_n(rst_n), .cf_kind(cf_kind), .src_idx(src_idx),
      .src_val(src_val), .dst_idx(dst_idx), .imm16(imm16), .imm26(imm26),
      .pc(pc), .taken(taken), .next_pc(next_pc), .link_we(link_we),
      .link_idx(link_idx), .link_val(link_val)
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic void model(input logic [31:0] cur, input logic [2:0] k,
                                 input logic [4:0] si, input logic [31:0] sv,
                                 input logic [4:0] di, input logic [15:0] i16,
                                 input logic [25:0] i26,
                                 output logic [31:0] nxt, output logic tk,
                                 output logic we, output logic [4:0] li);
      logic [31:0] v, p4, tgt;
      v   = (si == 0) ? 32'h0 : sv;
      p4  = cur + 32'd4;
      tk  = 1'b0;
      tgt = p4;
      case (k)
         3'd1: begin tk = (v == 0);  tgt = p4 + 32'($signed(i16) * 4); end
         3'd2: begin tk = (v != 0);  tgt = p4 + 32'($signed(i16) * 4); end
         3'd3, 3'd4: begin tk = 1'b1; tgt = (p4 & 32'hF000_0000) | (32'(i26) << 2); end
         3'd5, 3'd6: begin tk = 1'b1; tgt = v; end
         default: ;
      endcase
      nxt = tk ? tgt : p4;
      we  = (k == 3'd4) || (k == 3'd6 && di != 0);
      li  = (k == 3'd4) ? 5'd31 : di;
   endfunction

   // drive one instruction at a falling edge, check outputs, let the PC update
   task automatic step(input string tag, input logic [2:0] k, input logic [4:0] si,
                       input logic [31:0] sv, input logic [4:0] di,
                       input logic [15:0] i16, input logic [25:0] i26);
      logic [31:0] e_nxt;
      logic e_tk, e_we;
      logic [4:0] e_li;
      chk("R1", "pc", pc, exp_pc);
      cf_kind = k; src_idx = si; src_val = sv; dst_idx = di; imm16 = i16; imm26 = i26;
      #2ns;
      model(exp_pc, k, si, sv, di, i16, i26, e_nxt, e_tk, e_we, e_li);
      chk(tag, "next_pc", next_pc, e_nxt);
      chk(tag, "taken", 32'(taken), 32'(e_tk));
      chk(tag, "link_we", 32'(link_we), 32'(e_we));
      if (e_we) begin
         chk(tag, "link_idx", 32'(link_idx), 32'(e_li));
         chk(tag, "link_val", link_val, exp_pc + 32'd4);
      end
      exp_pc = e_nxt;
      @(negedge clk);
   endtask

   initial begin
      #(HALF * 2 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "pc in reset", pc, 32'h0);
      rst_n = 1'b1;
      step("R2",  3'd0, 5'd0, 32'h0,        5'd0, 16'h0,    26'h0);
      step("R3",  3'd1, 5'd3, 32'h0,        5'd0, 16'h0010, 26'h0);
      step("R3",  3'd1, 5'd3, 32'h5,        5'd0, 16'h0010, 26'h0);
      step("R4",  3'd2, 5'd3, 32'h5,        5'd0, 16'h0002, 26'h0);
      step("R5",  3'd2, 5'd3, 32'h5,        5'd0, 16'hFFFC, 26'h0);
      step("R4",  3'd2, 5'd3, 32'h0,        5'd0, 16'h0040, 26'h0);
      step("R10", 3'd1, 5'd0, 32'h1234,     5'd0, 16'h0008, 26'h0);
      step("R10", 3'd2, 5'd0, 32'h7,        5'd0, 16'h0008, 26'h0);
      step("R7",  3'd5, 5'd4, 32'h0FFF_FFFC, 5'd0, 16'h0,   26'h0);
      step("R6",  3'd3, 5'd0, 32'h0,        5'd0, 16'h0,    26'h0000123);
      step("R8",  3'd4, 5'd9, 32'h0,        5'd2, 16'h0,    26'h3FF_FFFF);
      step("R10", 3'd5, 5'd0, 32'hDEAD,     5'd0, 16'h0,    26'h0);
      step("R9",  3'd6, 5'd5, 32'h8000_0000, 5'd7, 16'h0,   26'h0);
      step("R9",  3'd6, 5'd5, 32'h0000_0100, 5'd0, 16'h0,   26'h0);
      step("R11", 3'd7, 5'd1, 32'h0,        5'd3, 16'h7FFF, 26'h1);
      step("R7",  3'd5, 5'd6, 32'hFFFF_FFFC, 5'd0, 16'h0,   26'h0);
      step("R2",  3'd0, 5'd0, 32'h0,        5'd0, 16'h0,    26'h0);
      step("R5",  3'd1, 5'd0, 32'h0,        5'd0, 16'h8000, 26'h0);
      for (int n = 0; n < 400; n++) begin
         logic [2:0] k;
         logic [4:0] si;
         logic [31:0] sv;
         k  = 3'($urandom_range(0, 7));
         si = 5'($urandom_range(0, 3));
         sv = ($urandom_range(0, 2) == 0) ? 32'h0 : $urandom;
         step("R11", k, si, sv, 5'($urandom_range(0, 31)), 16'($urandom), 26'($urandom));
      end
      rst_n = 1'b0;
      #1ns;
      chk("R1", "pc after reset", pc, 32'h0);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule